// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

This block is a 16-bit up-counter held as two byte halves. Software reaches it over a small byte-wide register bus, and one control byte picks how it behaves. The counter can step on the system clock, with a choice of every cycle or every twelfth cycle. It can instead step on falling edges of an external pin, which pass through a synchronizer first.

Three behaviours are available while the run bit is set:
- **Capture:** a falling edge on a capture pin latches the live count into a capture pair.
- **Auto-reload:** each wrap from 0xFFFF loads the count from a reload pair.
- **Baud generator:** the reload behaviour drives one-cycle transmit and/or receive rate ticks for a serial port. Either baud select bit overrides the capture/reload choice.

Every wrap also produces a one-cycle start pulse for an analog-to-digital converter. Overflow and capture-event flags are held until software clears them.

Top module: `tmr16_multi`

## Requirements
- R1: After reset, every register reads 0 and the outputs ovf_flag, evt_flag, adc_start, tx_tick and rx_tick are 0.
- R2: The bus address map is 0 control, 1 count low, 2 count high, 3 reload low, 4 reload high, 5 capture low, 6 capture high, 7 status. Status bit 0 is the overflow flag and bit 1 is the event flag. The capture registers are read-only. rdata is a combinational read of the register at addr. A write to either count byte replaces that byte and suppresses any count step on that edge.
- R3: The control bits are [0] run, [1] external clock, [2] capture select, [3] transmit baud, [4] receive baud, [5] divide-by-1 (0 = divide by 12) and [6] capture enable. With run = 0 the count holds its value whatever the other bits are.
- R4: With run = 1 and external clock = 0, the count steps every system clock when divide-by-1 is set, and otherwise on every twelfth clock. The divide-by-12 prescaler restarts from zero whenever run is 0, external clock is 1 or divide-by-1 is 1.
- R5: With run = 1 and external clock = 1, the count steps once per falling edge of ext_pin. The pin passes through two synchronizing flops and one history flop, so a fall steps the count on the third rising clock edge after the pin is first sampled low.
- R6: Auto-reload mode is run = 1, both baud bits 0 and capture select 0. In this mode a step from 0xFFFF loads the reload pair and sets ovf_flag.
- R7: Capture mode is run = 1, both baud bits 0 and capture select 1. In this mode a step from 0xFFFF wraps the count to 0 and sets ovf_flag.
- R8: In capture mode with capture enable set, a synchronized falling edge on cap_pin copies the count before that edge into the capture pair and sets evt_flag. In any other mode, or with capture enable clear, the edge changes neither.
- R9: With run = 1 and either baud bit set, the capture select bit is ignored. A step from 0xFFFF loads the reload pair and does not set ovf_flag. On the next cycle it gives a one-cycle tx_tick if transmit baud is set and a one-cycle rx_tick if receive baud is set.
- R10: Every step from 0xFFFF, in any mode, gives adc_start high for the one cycle after that edge.
- R11: Writing status clears each flag whose wdata bit is 1. A flag that is set on the same edge stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| ext_pin | input | 1 | External count input, asynchronous |
| cap_pin | input | 1 | Capture trigger input, asynchronous |
| ovf_flag | output | 1 | Sticky overflow flag |
| evt_flag | output | 1 | Sticky capture event flag |
| adc_start | output | 1 | One-cycle converter start pulse on wrap |
| tx_tick | output | 1 | One-cycle transmit baud tick |
| rx_tick | output | 1 | One-cycle receive baud tick |

## Verification
The assertions check the following on every cycle:
- The count holds while the block is off.
- A wrap lands on the reload value in reload and baud modes, and on zero in capture mode.
- Baud ticks follow only their select bits, always arrive together with the converter pulse, and never raise the overflow flag.
- The event flag rises only out of capture mode.

The bench's scenarios are needed for the rest:
- the exact step rate of the divide-by-12 prescaler;
- the synchronizer latency and single counting of pin edges;
- the byte that a capture latches;
- count writes that suppress a step;
- clearing the flags by writing status.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int unsigned BUS_W  = 8;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned CNT_W  = 2 * BUS_W;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd5;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd6;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd7;

    localparam int unsigned CB_RUN  = 0;
    localparam int unsigned CB_EXT  = 1;
    localparam int unsigned CB_CAP  = 2;
    localparam int unsigned CB_TX   = 3;
    localparam int unsigned CB_RX   = 4;
    localparam int unsigned CB_FAST = 5;
    localparam int unsigned CB_CEN  = 6;
    localparam int unsigned CTRL_USED = 7;

    localparam int unsigned SB_OVF = 0;
    localparam int unsigned SB_EVT = 1;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_RELOAD  = 2'd2,
        MODE_BAUD    = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  ext_clk;
        logic  fast;
        logic  cap_en;
        logic  tx_en;
        logic  rx_en;
    } cfg_t;

    typedef struct packed {
        logic [BUS_W-1:0] ctrl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic [CNT_W-1:0] cap;
        logic             ovf;
        logic             evt;
        logic             adc;
        logic             txt;
        logic             rxt;
    } state_t;

endpackage

// File: rtl/tmr16_fall_detect.sv
module tmr16_fall_detect #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
        fall = sh_q[STAGES] & ~sh_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
    parameter int unsigned DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bypass,
    output logic tick
);
    localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = 1'b0;
        cnt_d = '0;
        if (enable) begin
            if (bypass) begin
                tick = 1'b1;
            end else begin
                tick  = (cnt_q == PW'(DIV - 1));
                cnt_d = tick ? '0 : cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tmr16_mode_dec.sv
module tmr16_mode_dec
    import tmr16_pkg::*;
(
    input  logic [CTRL_USED-1:0] ctrl,
    output cfg_t                 cfg
);
    always_comb begin
        cfg.ext_clk = ctrl[CB_EXT];
        cfg.fast    = ctrl[CB_FAST];
        cfg.cap_en  = ctrl[CB_CEN];
        cfg.tx_en   = ctrl[CB_TX];
        cfg.rx_en   = ctrl[CB_RX];
        if (!ctrl[CB_RUN])                   cfg.mode = MODE_OFF;
        else if (ctrl[CB_TX] || ctrl[CB_RX]) cfg.mode = MODE_BAUD;
        else if (ctrl[CB_CAP])               cfg.mode = MODE_CAPTURE;
        else                                 cfg.mode = MODE_RELOAD;
    end
endmodule

// File: rtl/tmr16_multi.sv
module tmr16_multi
    import tmr16_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PRESC_DIV   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              ext_pin,
    input  logic              cap_pin,
    output logic              ovf_flag,
    output logic              evt_flag,
    output logic              adc_start,
    output logic              tx_tick,
    output logic              rx_tick
);
    localparam int unsigned NPINS = 2;

    state_t           st_d, st_q;
    cfg_t             cfg;
    logic [NPINS-1:0] pin_in, pin_fall;
    logic             pre_tick;
    logic             running;

    assign pin_in = {cap_pin, ext_pin};

    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        tmr16_fall_detect #(.STAGES(SYNC_STAGES)) u_fd (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pin_in[g]),
            .fall (pin_fall[g])
        );
    end

    tmr16_mode_dec u_dec (
        .ctrl(st_q.ctrl[CTRL_USED-1:0]),
        .cfg (cfg)
    );

    assign running = (cfg.mode != MODE_OFF);

    tmr16_prescaler #(.DIV(PRESC_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(running && !cfg.ext_clk),
        .bypass(cfg.fast),
        .tick  (pre_tick)
    );

    always_comb begin
        logic step, cnt_wr, ovf_set, evt_set, ovf_clr, evt_clr;
        st_d     = st_q;
        st_d.adc = 1'b0;
        st_d.txt = 1'b0;
        st_d.rxt = 1'b0;
        ovf_set  = 1'b0;
        evt_set  = 1'b0;
        ovf_clr  = 1'b0;
        evt_clr  = 1'b0;

        cnt_wr = wr_en && (addr == A_CNT_LO || addr == A_CNT_HI);
        step   = running && (cfg.ext_clk ? pin_fall[0] : pre_tick);

        if (step && !cnt_wr) begin
            if (&st_q.cnt) begin
                st_d.adc = 1'b1;
                st_d.cnt = (cfg.mode == MODE_CAPTURE) ? '0 : st_q.rld;
                if (cfg.mode == MODE_BAUD) begin
                    st_d.txt = cfg.tx_en;
                    st_d.rxt = cfg.rx_en;
                end else begin
                    ovf_set = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (cfg.mode == MODE_CAPTURE && cfg.cap_en && pin_fall[1]) begin
            st_d.cap = st_q.cnt;
            evt_set  = 1'b1;
        end

        if (wr_en) begin
            case (addr)
                A_CTRL:   st_d.ctrl             = wdata;
                A_CNT_LO: st_d.cnt[BUS_W-1:0]   = wdata;
                A_CNT_HI: st_d.cnt[CNT_W-1:BUS_W] = wdata;
                A_RLD_LO: st_d.rld[BUS_W-1:0]   = wdata;
                A_RLD_HI: st_d.rld[CNT_W-1:BUS_W] = wdata;
                A_STAT: begin
                    ovf_clr = wdata[SB_OVF];
                    evt_clr = wdata[SB_EVT];
                end
                default: ;
            endcase
        end

        st_d.ovf = (st_q.ovf && !ovf_clr) || ovf_set;
        st_d.evt = (st_q.evt && !evt_clr) || evt_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata = st_q.ctrl;
            A_CNT_LO: rdata = st_q.cnt[BUS_W-1:0];
            A_CNT_HI: rdata = st_q.cnt[CNT_W-1:BUS_W];
            A_RLD_LO: rdata = st_q.rld[BUS_W-1:0];
            A_RLD_HI: rdata = st_q.rld[CNT_W-1:BUS_W];
            A_CAP_LO: rdata = st_q.cap[BUS_W-1:0];
            A_CAP_HI: rdata = st_q.cap[CNT_W-1:BUS_W];
            A_STAT: begin
                rdata[SB_OVF] = st_q.ovf;
                rdata[SB_EVT] = st_q.evt;
            end
            default: ;
        endcase
    end

    assign ovf_flag  = st_q.ovf;
    assign evt_flag  = st_q.evt;
    assign adc_start = st_q.adc;
    assign tx_tick   = st_q.txt;
    assign rx_tick   = st_q.rxt;
endmodule

// File: rtl/tmr16_multi_chk.sv
module tmr16_multi_chk
    import tmr16_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input mode_e            mode,
    input logic             tx_en,
    input logic             rx_en,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] rld,
    input logic             ovf_flag,
    input logic             evt_flag,
    input logic             adc_start,
    input logic             tx_tick,
    input logic             rx_tick
);
    // R3
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF && !wr_en) |=> $stable(cnt));

    // R6
    reload_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start && $past(mode != MODE_CAPTURE)) |-> (cnt == $past(rld)));

    // R7
    capture_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start && $past(mode == MODE_CAPTURE)) |-> (cnt == '0));

    // R6
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> adc_start);

    // R9
    baud_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_tick || rx_tick) |-> !$rose(ovf_flag));

    // R9
    tx_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |-> $past(tx_en));

    // R9
    rx_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick |-> $past(rx_en));

    // R10
    tick_adc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_tick || rx_tick) |-> adc_start);

    // R8
    evt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flag) |-> $past(mode == MODE_CAPTURE));
endmodule

bind tmr16_multi tmr16_multi_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .mode     (cfg.mode),
    .tx_en    (cfg.tx_en),
    .rx_en    (cfg.rx_en),
    .cnt      (st_q.cnt),
    .rld      (st_q.rld),
    .ovf_flag (ovf_flag),
    .evt_flag (evt_flag),
    .adc_start(adc_start),
    .tx_tick  (tx_tick),
    .rx_tick  (rx_tick)
);

// File: tb/test_tmr16_multi.sv
`timescale 1ns/1ps
module test_tmr16_multi;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       ext_pin = 1'b1;
    logic       cap_pin = 1'b1;
    logic       ovf_flag, evt_flag, adc_start, tx_tick, rx_tick;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int m_ctrl = 0, m_cnt = 0, m_rld = 0, m_cap = 0, m_pre = 0;
    bit m_ovf = 0, m_evt = 0, m_adc = 0, m_tx = 0, m_rx = 0;
    bit p1 = 0, p2 = 0, p3 = 0, c1 = 0, c2 = 0, c3 = 0;

    tmr16_multi i_tmr16_multi (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_pin(ext_pin), .cap_pin(cap_pin),
        .ovf_flag(ovf_flag), .evt_flag(evt_flag), .adc_start(adc_start),
        .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    always #10 clk = ~clk;

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin : model
        bit pf, cf, run, ext, cp, tx, rx, fast, cen, tk, inc, baud, capm;
        bit ovs, evs, ovc, evc, cw;
        int nxt;
        if (!rst_n) begin
            m_ctrl = 0; m_cnt = 0; m_rld = 0; m_cap = 0; m_pre = 0;
            m_ovf = 0; m_evt = 0; m_adc = 0; m_tx = 0; m_rx = 0;
            p1 = 0; p2 = 0; p3 = 0; c1 = 0; c2 = 0; c3 = 0;
        end else begin
            pf = p3 && !p2;
            cf = c3 && !c2;
            p3 = p2; p2 = p1; p1 = ext_pin;
            c3 = c2; c2 = c1; c1 = cap_pin;
            run  = m_ctrl[0]; ext = m_ctrl[1]; cp = m_ctrl[2];
            tx   = m_ctrl[3]; rx  = m_ctrl[4]; fast = m_ctrl[5]; cen = m_ctrl[6];
            if (!run || ext || fast) begin
                tk = run && !ext;
                m_pre = 0;
            end else begin
                tk = (m_pre == 11);
                m_pre = tk ? 0 : m_pre + 1;
            end
            cw   = wr_en && (addr == 3'd1 || addr == 3'd2);
            inc  = run && (ext ? pf : tk) && !cw;
            baud = tx || rx;
            capm = run && !baud && cp;
            m_adc = 0; m_tx = 0; m_rx = 0; ovs = 0; evs = 0; ovc = 0; evc = 0;
            nxt = m_cnt;
            if (inc) begin
                if (m_cnt == 16'hFFFF) begin
                    m_adc = 1;
                    nxt = capm ? 0 : m_rld;
                    if (baud) begin m_tx = tx; m_rx = rx; end
                    else ovs = 1;
                end else nxt = m_cnt + 1;
            end
            if (capm && cen && cf) begin m_cap = m_cnt; evs = 1; end
            if (wr_en) begin
                case (addr)
                    3'd0: m_ctrl = wdata;
                    3'd1: nxt = (nxt & 16'hFF00) | wdata;
                    3'd2: nxt = (nxt & 16'h00FF) | (int'(wdata) << 8);
                    3'd3: m_rld = (m_rld & 16'hFF00) | wdata;
                    3'd4: m_rld = (m_rld & 16'h00FF) | (int'(wdata) << 8);
                    3'd7: begin ovc = wdata[0]; evc = wdata[1]; end
                    default: ;
                endcase
            end
            m_cnt = nxt;
            m_ovf = (m_ovf && !ovc) || ovs;
            m_evt = (m_evt && !evc) || evs;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Registered outputs compared every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 ovf_flag", ovf_flag, m_ovf);
            chk("R8 evt_flag", evt_flag, m_evt);
            chk("R10 adc_start", adc_start, m_adc);
            chk("R9 tx_tick", tx_tick, m_tx);
            chk("R9 rx_tick", rx_tick, m_rx);
        end
    end

    function automatic int model_read(input int a);
        case (a)
            0: return m_ctrl;
            1: return m_cnt & 255;
            2: return (m_cnt >> 8) & 255;
            3: return m_rld & 255;
            4: return (m_rld >> 8) & 255;
            5: return m_cap & 255;
            6: return (m_cap >> 8) & 255;
            default: return (int'(m_evt) << 1) | int'(m_ovf);
        endcase
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a[2:0]; wdata = d[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input string req);
        @(negedge clk);
        addr = a[2:0];
        #5;
        chk(req, rdata, model_read(a));
    endtask

    task automatic rd_abs(input int a, input int exp, input string req);
        @(negedge clk);
        addr = a[2:0];
        #5;
        chk(req, rdata, exp);
    endtask

    task automatic pin_pulse(input int w);
        @(negedge clk); ext_pin = 1'b0;
        idle(w);
        ext_pin = 1'b1;
        idle(w);
    endtask

    task automatic cap_pulse();
        @(negedge clk); cap_pin = 1'b0;
        idle(3);
        cap_pin = 1'b1;
        idle(4);
    endtask

    task automatic set_cnt(input int v);
        wr(1, v & 255);
        wr(2, (v >> 8) & 255);
    endtask

    task automatic set_rld(input int v);
        wr(3, v & 255);
        wr(4, (v >> 8) & 255);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;

        // R1: reset state of every register
        for (int a = 0; a < 8; a++) rd_abs(a, 0, "R1 reset register");

        // R3: off holds count whatever the other bits
        set_cnt(16'h1234);
        wr(0, 8'h7E);
        idle(40);
        rd_abs(1, 8'h34, "R3 hold low");
        rd_abs(2, 8'h12, "R3 hold high");
        wr(0, 8'h00);

        // R6 with R4 divide-by-1
        set_rld(16'hFFF0);
        set_cnt(16'hFFFA);
        wr(0, 8'h21);
        idle(30);
        rd_abs(7, 1, "R6 overflow flag set");
        rd(1, "R6 reload count low");
        rd(2, "R6 reload count high");

        // R2: count write while running suppresses the step
        wr(1, 8'h00);
        rd(1, "R2 count write low");
        rd(3, "R2 reload low readback");
        rd_abs(4, 8'hFF, "R2 reload high readback");

        // R11: clear overflow by status write
        wr(0, 8'h00);
        wr(7, 8'h01);
        rd_abs(7, 0, "R11 overflow cleared");

        // R4 divide-by-12
        set_rld(16'h1000);
        set_cnt(16'hFFF8);
        wr(0, 8'h01);
        idle(200);
        rd(1, "R4 div12 low");
        rd(2, "R4 div12 high");
        wr(0, 8'h00);

        // R5: external falling edges
        set_rld(16'h0055);
        set_cnt(16'hFFFD);
        wr(0, 8'h03);
        for (int i = 0; i < 5; i++) pin_pulse(2);
        for (int i = 0; i < 3; i++) pin_pulse(1);
        idle(4);
        rd(1, "R5 ext count low");
        rd_abs(2, 8'h00, "R5 ext count high");
        rd(7, "R5 ext overflow status");
        wr(0, 8'h00);
        wr(7, 8'h03);

        // R7 and R8: capture mode
        set_cnt(16'hFFE0);
        wr(0, 8'h65);
        idle(5);
        cap_pulse();
        rd(5, "R8 capture low");
        rd(6, "R8 capture high");
        rd_abs(7, 2, "R8 event flag");
        idle(30);
        rd(1, "R7 wrap low");
        rd(2, "R7 wrap high");
        rd(7, "R7 overflow in capture");

        // R8: capture disabled, then wrong mode
        wr(0, 8'h00);
        wr(7, 8'h03);
        wr(0, 8'h25);
        cap_pulse();
        rd(5, "R8 no capture without enable");
        rd_abs(7, 0, "R8 no event without enable");
        wr(0, 8'h61);
        cap_pulse();
        rd(6, "R8 no capture in reload mode");
        rd(7, "R8 no event in reload mode");

        // R9: baud modes, capture select and capture pin ignored
        wr(0, 8'h00);
        wr(7, 8'h03);
        set_rld(16'hFFFC);
        set_cnt(16'hFFFC);
        wr(0, 8'h6D);
        cap_pulse();
        idle(20);
        rd_abs(7, 0, "R9 no flags in tx baud");
        wr(0, 8'h35);
        idle(20);
        rd(1, "R9 rx baud count");
        wr(0, 8'h39);
        idle(20);
        rd_abs(7, 0, "R9 no flags in tx+rx baud");
        wr(0, 8'h19);
        idle(300);
        rd(1, "R10 slow baud count");

        wr(0, 8'h00);
        idle(2);
        finish_run();
    end
endmodule